// File: doc/BRIEF.md
# Timestamped Cluster Sample Unpacker

This block turns stored logic-capture memory into a uniform stream of 16-bit samples. Memory is read as 1024-byte chunks of 64 clusters. Each 16-byte cluster holds a 16-bit timestamp, counted in 20 ns event periods, and then seven 16-bit event words. All values are little-endian. One event carries one, two or four time slots of the active probes, depending on the channel mode. The block rebuilds time in three ways. It repeats the last sample to cover stretches the timestamps skip. It splits each event into its time slots. It marks the one sample that sits at the recorded trigger position.

Software pulses `start` at the beginning of a capture. At that pulse the block takes the channel mode, the trigger enable and the raw 24-bit trigger position, and clears its carried timestamp and sample. Chunks are then streamed in byte by byte over a valid/ready handshake. Output samples leave one per cycle with `out_valid`. `out_trig` is raised alongside the sample at the trigger point.

The control is one state machine. S_IDLE waits for the first start. S_TS_LO and S_TS_HI take the timestamp bytes. S_PAD repeats the last sample. S_EV_LO and S_EV_HI take an event word. S_EMIT sends the time slots of that event. The transitions are:
- start goes from any state to S_TS_LO.
- S_TS_LO goes to S_TS_HI on a byte.
- S_TS_HI goes to S_PAD on a byte when padding is due, otherwise to S_EV_LO.
- S_PAD goes to S_EV_LO when its count runs out.
- S_EV_LO goes to S_EV_HI on a byte.
- S_EV_HI goes to S_EMIT on a byte.
- S_EMIT goes to S_EV_LO after the last slot of an event, or to S_TS_LO after the seventh event of a cluster.

Top module: `cluster_unpacker`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `out_trig` are low. From the cycle after a `start` pulse, `in_ready` is high.
- R2: Mode 0 (16 probes, one slot per event) sends each event word unchanged as one sample. The low byte of the word comes first in the stream.
- R3: Mode 1 (8 probes, two slots) sends two samples per event. In sample k, bit l is event bit 2l+k, and bits 15:8 are zero.
- R4: Mode 2 (4 probes, four slots) sends four samples per event. In sample k, bit l is event bit 4l+k, and bits 15:4 are zero. Mode 3 acts as mode 2.
- R5: Before the samples of a cluster, the block sends D×S − 7×S copies of the last sample sent, when that count is positive. D is the timestamp step from the previous cluster and S is the slots per event.
- R6: The timestamp step D is taken modulo 2^16, so a timestamp that wraps past zero gives a small step. A step below 7 gives no padding.
- R7: `in_ready` is low in every cycle where `out_valid` is high, during both padding and slot output.
- R8: The last timestamp and the last sample carry over from one chunk to the next. A `start` pulse resets both to zero.
- R9: The raw trigger position is reduced by one. If its low 9 bits are then 0x1FF, it is reduced by a further 64. Bits 23:9 of the result give the chunk index within the capture, and bits 8:0 give the position P inside that chunk.
- R10: In mode 0, P is reduced by 7 and clamped at 0. The trigger cluster is P/7. The flagged sample is the one at index (P mod 7) of that cluster, counting from 0 over its event samples.
- R11: In modes 1 to 3, P is used as is. The flagged sample is at index max(P mod 7 − 3, 0) of cluster P/7.
- R12: `out_trig` is only high together with `out_valid`. It is high at most once per capture, and never when the trigger enable captured at `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin capture: latch settings, clear carried state |
| mode | input | 2 | Channel mode: 0 = 16 probes, 1 = 8 probes, 2/3 = 4 probes |
| trig_en | input | 1 | A trigger was recorded for this capture |
| trig_pos | input | 24 | Raw recorded trigger position |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input chunk byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Output sample |
| out_trig | output | 1 | Sample at the trigger point |

## Verification
- The first padded copy appears in the cycle after the edge that accepts a timestamp's high byte.
- The first slot of an event appears in the cycle after the edge that accepts the event's high byte.
- Samples then follow one per cycle, with `in_ready` held low until the run ends.
- `in_ready` rises in the cycle after `start`.

The bench reads ports only at falling edges, halfway between the edges that change the registers. Each sample and its trigger bit are compared in arrival order with a stream that the bench models from the requirements. A test waits until the output has been idle long enough to cover a full event before it compares the counts. This ties each result to the cycle the handshake allows rather than to a fixed latency.

// File: rtl/cu_pkg.sv
package cu_pkg;
    localparam int SAMPLE_W  = 16;
    localparam int BYTE_W    = 8;
    localparam int TS_W      = 16;
    localparam int EVENTS    = 7;
    localparam int CLUSTERS  = 64;
    localparam int POS_W     = 24;
    localparam int WIN_W     = 9;
    localparam int CHUNK_W   = POS_W - WIN_W;
    localparam int CL_W      = $clog2(CLUSTERS);
    localparam int EV_W      = $clog2(EVENTS);
    localparam int LG_W      = 2;
    localparam int K_W       = 2;
    localparam int PAD_W     = TS_W + K_W;
    localparam int FAST_OFF  = 3;
    localparam int SLIP      = 64;

    typedef enum logic [2:0] {
        S_IDLE, S_TS_LO, S_TS_HI, S_PAD, S_EV_LO, S_EV_HI, S_EMIT
    } cu_state_t;

    // log2 of time slots per event for a channel mode code
    function automatic logic [LG_W-1:0] mode_to_lg(input logic [1:0] m);
        case (m)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction
endpackage

// File: rtl/cu_event_unpack.sv
module cu_event_unpack
    import cu_pkg::*;
(
    input  logic [SAMPLE_W-1:0] event_w,
    input  logic [LG_W-1:0]     lg,
    input  logic [K_W-1:0]      slot,
    output logic [SAMPLE_W-1:0] sample
);
    always_comb begin
        sample = '0;
        for (int l = 0; l < SAMPLE_W; l++) begin
            unique case (lg)
                2'd0: sample[l] = event_w[l];
                2'd1: if (l < SAMPLE_W/2) sample[l] = event_w[2*l + int'(slot)];
                default: if (l < SAMPLE_W/4) sample[l] = event_w[4*l + int'(slot)];
            endcase
        end
    end
endmodule

// File: rtl/cu_gap_calc.sv
module cu_gap_calc
    import cu_pkg::*;
(
    input  logic [TS_W-1:0]  ts_new,
    input  logic [TS_W-1:0]  ts_last,
    input  logic [LG_W-1:0]  lg,
    output logic             pad_any,
    output logic [PAD_W-1:0] pad_cnt
);
    logic [TS_W-1:0]  step;
    logic [PAD_W-1:0] scaled;
    logic [PAD_W-1:0] base;

    always_comb begin
        step    = ts_new - ts_last;
        scaled  = {{K_W{1'b0}}, step} << lg;
        base    = PAD_W'(EVENTS) << lg;
        pad_any = scaled > base;
        pad_cnt = scaled - base;
    end
endmodule

// File: rtl/cu_trig_locator.sv
module cu_trig_locator
    import cu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               en_in,
    input  logic [POS_W-1:0]   pos_raw,
    input  logic [LG_W-1:0]    lg,
    output logic               armed,
    output logic [CHUNK_W-1:0] tgt_chunk,
    output logic [WIN_W-1:0]   tgt_cluster,
    output logic [WIN_W-1:0]   tgt_sidx
);
    logic [POS_W-1:0] pos_dec, pos_adj;
    logic [WIN_W-1:0] win, p, cl, rem, off, sidx;

    always_comb begin
        pos_dec = pos_raw - POS_W'(1);
        pos_adj = (pos_dec[WIN_W-1:0] == {WIN_W{1'b1}}) ? pos_dec - POS_W'(SLIP) : pos_dec;
        win     = pos_adj[WIN_W-1:0];
        if (lg == 2'd0)
            p = (win >= WIN_W'(EVENTS)) ? win - WIN_W'(EVENTS) : '0;
        else
            p = win;
        cl   = p / WIN_W'(EVENTS);
        rem  = p % WIN_W'(EVENTS);
        off  = (lg == 2'd0) ? '0 : WIN_W'(FAST_OFF);
        sidx = (rem > off) ? rem - off : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed       <= 1'b0;
            tgt_chunk   <= '0;
            tgt_cluster <= '0;
            tgt_sidx    <= '0;
        end else if (load) begin
            armed       <= en_in;
            tgt_chunk   <= pos_adj[POS_W-1:WIN_W];
            tgt_cluster <= cl;
            tgt_sidx    <= sidx;
        end
    end
endmodule

// File: rtl/cluster_unpacker.sv
module cluster_unpacker
    import cu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          mode,
    input  logic                trig_en,
    input  logic [POS_W-1:0]    trig_pos,
    input  logic                in_valid,
    input  logic [BYTE_W-1:0]   in_data,
    output logic                in_ready,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_trig
);
    cu_state_t state, state_nx;

    logic [LG_W-1:0]     lg;
    logic [BYTE_W-1:0]   ts_lo, ev_lo;
    logic [TS_W-1:0]     last_ts;
    logic [SAMPLE_W-1:0] last_s, event_w, slot_sample;
    logic [EV_W-1:0]     ev_idx;
    logic [K_W-1:0]      slot, slot_max;
    logic [CL_W-1:0]     cl_idx;
    logic [CHUNK_W-1:0]  chunk_cnt;
    logic [PAD_W-1:0]    pad_cnt, gap_cnt;
    logic                gap_any, fired, acc, trig_hit;
    logic                armed;
    logic [CHUNK_W-1:0]  tgt_chunk;
    logic [WIN_W-1:0]    tgt_cluster, tgt_sidx, sidx_now;
    logic [TS_W-1:0]     ts_new;

    assign ts_new   = {in_data, ts_lo};
    assign acc      = in_valid && in_ready;
    assign slot_max = K_W'((1 << lg) - 1);
    assign sidx_now = (WIN_W'(ev_idx) << lg) + WIN_W'(slot);

    cu_event_unpack u_unpack (
        .event_w (event_w),
        .lg      (lg),
        .slot    (slot),
        .sample  (slot_sample)
    );

    cu_gap_calc u_gap (
        .ts_new  (ts_new),
        .ts_last (last_ts),
        .lg      (lg),
        .pad_any (gap_any),
        .pad_cnt (gap_cnt)
    );

    cu_trig_locator u_trig (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start),
        .en_in       (trig_en),
        .pos_raw     (trig_pos),
        .lg          (mode_to_lg(mode)),
        .armed       (armed),
        .tgt_chunk   (tgt_chunk),
        .tgt_cluster (tgt_cluster),
        .tgt_sidx    (tgt_sidx)
    );

    assign trig_hit = armed && !fired && (state == S_EMIT)
                   && (chunk_cnt == tgt_chunk)
                   && (WIN_W'(cl_idx) == tgt_cluster)
                   && (sidx_now == tgt_sidx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= S_IDLE;
        else if (start) state <= S_TS_LO;
        else            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  state_nx = S_IDLE;
            S_TS_LO: if (in_valid) state_nx = S_TS_HI;
            S_TS_HI: if (in_valid) state_nx = gap_any ? S_PAD : S_EV_LO;
            S_PAD:   if (pad_cnt == PAD_W'(1)) state_nx = S_EV_LO;
            S_EV_LO: if (in_valid) state_nx = S_EV_HI;
            S_EV_HI: if (in_valid) state_nx = S_EMIT;
            S_EMIT:  if (slot == slot_max)
                         state_nx = (ev_idx == EV_W'(EVENTS-1)) ? S_TS_LO : S_EV_LO;
            default: state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg <= '0; ts_lo <= '0; ev_lo <= '0; last_ts <= '0; last_s <= '0;
            event_w <= '0; ev_idx <= '0; slot <= '0; cl_idx <= '0;
            chunk_cnt <= '0; pad_cnt <= '0; fired <= 1'b0;
        end else if (start) begin
            lg <= mode_to_lg(mode);
            last_ts <= '0; last_s <= '0; ev_idx <= '0; slot <= '0;
            cl_idx <= '0; chunk_cnt <= '0; pad_cnt <= '0; fired <= 1'b0;
        end else begin
            unique case (state)
                S_TS_LO: if (acc) ts_lo <= in_data;
                S_TS_HI: if (acc) begin
                    last_ts <= ts_new;
                    pad_cnt <= gap_cnt;
                    ev_idx  <= '0;
                end
                S_PAD:   pad_cnt <= pad_cnt - PAD_W'(1);
                S_EV_LO: if (acc) ev_lo <= in_data;
                S_EV_HI: if (acc) begin
                    event_w <= {in_data, ev_lo};
                    slot    <= '0;
                end
                S_EMIT: begin
                    last_s <= slot_sample;
                    if (trig_hit) fired <= 1'b1;
                    if (slot == slot_max) begin
                        slot <= '0;
                        if (ev_idx == EV_W'(EVENTS-1)) begin
                            ev_idx <= '0;
                            cl_idx <= cl_idx + CL_W'(1);
                            if (cl_idx == CL_W'(CLUSTERS-1)) chunk_cnt <= chunk_cnt + CHUNK_W'(1);
                        end else begin
                            ev_idx <= ev_idx + EV_W'(1);
                        end
                    end else begin
                        slot <= slot + K_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_trig  = 1'b0;
        unique case (state)
            S_TS_LO, S_TS_HI, S_EV_LO, S_EV_HI: in_ready = 1'b1;
            S_PAD: begin
                out_valid = 1'b1;
                out_data  = last_s;
            end
            S_EMIT: begin
                out_valid = 1'b1;
                out_data  = slot_sample;
                out_trig  = trig_hit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cluster_unpacker_chk.sv
module cluster_unpacker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [1:0]  mode,
    input logic        trig_en,
    input logic        in_ready,
    input logic        out_valid,
    input logic [15:0] out_data,
    input logic        out_trig
);
    logic [1:0] cmode;
    logic       seen;
    logic       en_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmode <= 2'd0; seen <= 1'b0; en_cap <= 1'b0;
        end else if (start) begin
            cmode <= mode; seen <= 1'b0; en_cap <= trig_en;
        end else if (out_trig) begin
            seen <= 1'b1;
        end
    end

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R1
    start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> in_ready);

    // R12
    trig_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_trig |-> (out_valid && en_cap));

    // R12
    trig_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_trig && !start) |-> !seen);

    // R3
    x2_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cmode == 2'd1) |-> (out_data[15:8] == 8'h00));

    // R4
    x4_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cmode[1]) |-> (out_data[15:4] == 12'h000));
endmodule

bind cluster_unpacker cluster_unpacker_chk u_chk (.*);

// File: tb/cluster_unpacker_tb.sv
module cluster_unpacker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        trig_en = 1'b0;
    logic [23:0] trig_pos = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, out_valid, out_trig;
    logic [15:0] out_data;

    always #2 clk = ~clk;

    cluster_unpacker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .trig_en(trig_en), .trig_pos(trig_pos),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_trig(out_trig)
    );

    int checks = 0, failures = 0;
    logic [7:0]  chunk [0:1023];
    logic [16:0] exp_mem [0:131071];
    int exp_n, got_n, mm_cnt, mm_at, ready_bad, trig_got;
    logic [16:0] mm_got, mm_exp;

    // model state
    logic [15:0] m_ts, m_s;
    int m_chunk, m_spe, t_chunk, t_cl, t_sidx;
    bit t_en, m_fired;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (in_ready) ready_bad++;
            if (out_trig) trig_got++;
            if (got_n >= exp_n || {out_trig, out_data} !== exp_mem[got_n]) begin
                if (mm_cnt == 0) begin
                    mm_at = got_n; mm_got = {out_trig, out_data};
                    mm_exp = (got_n < exp_n) ? exp_mem[got_n] : 17'h1ffff;
                end
                mm_cnt++;
            end
            got_n++;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] model_unpack(logic [15:0] ev, int spe, int k);
        logic [15:0] s = '0;
        for (int l = 0; l < 16 / spe; l++) s[l] = ev[l * spe + k];
        return s;
    endfunction

    task automatic push(logic [16:0] v);
        if (exp_n < 131072) exp_mem[exp_n] = v;
        exp_n++;
    endtask

    task automatic model_chunk();
        for (int c = 0; c < 64; c++) begin
            logic [15:0] ts = {chunk[16*c+1], chunk[16*c]};
            logic [15:0] d = ts - m_ts;
            int pad = int'(d) * m_spe - 7 * m_spe;
            for (int i = 0; i < pad; i++) push({1'b0, m_s});
            m_ts = ts;
            for (int e = 0; e < 7; e++) begin
                logic [15:0] ev = {chunk[16*c+3+2*e], chunk[16*c+2+2*e]};
                for (int k = 0; k < m_spe; k++) begin
                    logic [15:0] s = model_unpack(ev, m_spe, k);
                    bit tg = t_en && !m_fired && m_chunk == t_chunk && c == t_cl
                             && (e * m_spe + k) == t_sidx;
                    if (tg) m_fired = 1;
                    push({tg, s});
                    m_s = s;
                end
            end
        end
        m_chunk++;
    endtask

    task automatic fill_chunk(int ts0, int step, int seed);
        for (int c = 0; c < 64; c++) begin
            logic [15:0] ts = 16'(ts0 + c * step);
            chunk[16*c] = ts[7:0]; chunk[16*c+1] = ts[15:8];
            for (int e = 0; e < 7; e++) begin
                logic [15:0] ev = 16'(c * 311) ^ 16'(e * 6973) ^ 16'(seed * 40503);
                chunk[16*c+2+2*e] = ev[7:0]; chunk[16*c+3+2*e] = ev[15:8];
            end
        end
    endtask

    task automatic set_ts(int c, logic [15:0] ts);
        chunk[16*c] = ts[7:0]; chunk[16*c+1] = ts[15:8];
    endtask

    task automatic bstart(logic [1:0] md, bit en, logic [23:0] raw);
        logic [23:0] pos;
        int w, p, r, off;
        mode = md; trig_en = en; trig_pos = raw;
        m_spe = (md == 0) ? 1 : (md == 1) ? 2 : 4;
        pos = raw - 24'd1;
        if (pos[8:0] == 9'h1ff) pos = pos - 24'd64;
        t_chunk = int'(pos[23:9]);
        w = int'(pos[8:0]);
        p = (md == 0) ? ((w >= 7) ? w - 7 : 0) : w;
        t_cl = p / 7; r = p % 7; off = (md == 0) ? 0 : 3;
        t_sidx = (r > off) ? r - off : 0;
        t_en = en; m_fired = 0; m_ts = 0; m_s = 0; m_chunk = 0;
        exp_n = 0; got_n = 0; mm_cnt = 0; ready_bad = 0; trig_got = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(in_ready === 1'b1, "R1", "in_ready after start", int'(in_ready), 1);
    endtask

    task automatic send_chunk(bit gaps);
        model_chunk();
        for (int i = 0; i < 1024; i++) begin
            bit rdy;
            in_valid = 1'b1; in_data = chunk[i];
            do begin rdy = in_ready; @(negedge clk); end while (!rdy);
            if (gaps && (i % 5 == 4)) begin in_valid = 1'b0; @(negedge clk); end
        end
        in_valid = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic check_stream(string req, int exp_trigs);
        chk(got_n == exp_n, req, "sample count", got_n, exp_n);
        if (mm_cnt != 0)
            $display("FAIL %s first mismatch at %0d actual=%h expected=%h", req, mm_at, mm_got, mm_exp);
        chk(mm_cnt == 0, req, "mismatched samples", mm_cnt, 0);
        chk(trig_got == exp_trigs, req, "trigger flags", trig_got, exp_trigs);
    endtask

    task automatic t_reset();
        chk(in_ready === 1'b0, "R1", "in_ready at reset", int'(in_ready), 0);
        chk(out_valid === 1'b0, "R1", "out_valid at reset", int'(out_valid), 0);
        chk(out_trig === 1'b0, "R1", "out_trig at reset", int'(out_trig), 0);
    endtask

    task automatic t_mode0();   // R2
        bstart(2'd0, 1'b0, 24'd0);
        fill_chunk(0, 7, 1); send_chunk(1'b0);
        check_stream("R2", 0);
    endtask

    task automatic t_mode1();   // R3
        bstart(2'd1, 1'b0, 24'd0);
        fill_chunk(0, 7, 2); send_chunk(1'b1);
        check_stream("R3", 0);
    endtask

    task automatic t_mode2();   // R4, mode 3 acts as mode 2
        bstart(2'd3, 1'b0, 24'd0);
        fill_chunk(0, 7, 3); send_chunk(1'b0);
        check_stream("R4", 0);
    endtask

    task automatic t_gap();     // R5, R7
        bstart(2'd1, 1'b0, 24'd0);
        fill_chunk(0, 9, 4); send_chunk(1'b1);
        check_stream("R5", 0);
        chk(ready_bad == 0, "R7", "in_ready high while emitting", ready_bad, 0);
    endtask

    task automatic t_wrap();    // R6
        bstart(2'd0, 1'b0, 24'd0);
        fill_chunk(20, 7, 5);
        set_ts(0, 16'hfff8); set_ts(1, 16'hffff); set_ts(2, 16'h0006);
        set_ts(3, 16'h000a); set_ts(4, 16'h0014);
        send_chunk(1'b0);
        check_stream("R6", 0);
    endtask

    task automatic t_carry();   // R8
        bstart(2'd2, 1'b0, 24'd0);
        fill_chunk(0, 7, 6); send_chunk(1'b0);
        fill_chunk(451, 7, 7); send_chunk(1'b0);
        check_stream("R8", 0);
        bstart(2'd2, 1'b0, 24'd0);
        fill_chunk(9, 7, 8); send_chunk(1'b0);
        check_stream("R8", 0);
    endtask

    task automatic t_trig_slow();   // R9, R10
        bstart(2'd0, 1'b1, 24'd543);
        fill_chunk(0, 7, 9); send_chunk(1'b0);
        fill_chunk(448, 7, 10); send_chunk(1'b0);
        check_stream("R10", 1);
        bstart(2'd0, 1'b1, 24'd512);
        fill_chunk(0, 7, 11); send_chunk(1'b0);
        check_stream("R9", 1);
    endtask

    task automatic t_trig_fast();   // R11, R12
        bstart(2'd2, 1'b1, 24'd21);
        fill_chunk(0, 7, 12); send_chunk(1'b0);
        fill_chunk(448, 7, 13); send_chunk(1'b0);
        check_stream("R11", 1);
        bstart(2'd1, 1'b1, 24'd16);
        fill_chunk(0, 7, 14); send_chunk(1'b0);
        check_stream("R11", 1);
        bstart(2'd2, 1'b0, 24'd21);
        fill_chunk(0, 7, 15); send_chunk(1'b0);
        check_stream("R12", 0);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_mode1();
        t_mode2();
        t_gap();
        t_wrap();
        t_carry();
        t_trig_slow();
        t_trig_fast();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule